// File: doc/BRIEF.md
# Eight-bit tick timer with clear-on-compare

An eight-bit up-counter that advances only on cycles where a timer tick enable is high, with one compare register and two operating modes chosen by a single control bit. In free-running mode the count rolls over from 0xFF to 0x00 and marks the rollover in a sticky overflow flag. In clear-on-compare mode the compare register acts as the top value: the tick on which the count equals it returns the count to zero. In both modes an equality on a tick sets a compare flag.

Software reaches the block through a plain single-cycle write port (address, data, write strobe) and reads the live count from a dedicated output. A counter write always beats counting and masks compare detection for the following tick, so a written value equal to the compare value never produces a match. Each flag drives an interrupt request gated by its own enable bit. An acknowledge input per flag, or a write-one-to-clear access, clears it. No stream data flows through this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `tick_timer`

## Requirements
- R1: After reset the count, the compare value, the mode bit, both interrupt enables and both flags are all zero.
- R2: The count changes only on a cycle with tick_en high or a counter write; on a tick without a write it advances by one unless R5 clears it.
- R3: In free-running mode a tick at count 0xFF gives count 0x00 and sets the overflow flag, both visible on the cycle after that tick.
- R4: The overflow flag is sticky: once set it stays set until ack_ovf is high or a flag-clear write has bit 0 set.
- R5: With the mode bit set (address 2, bit 0 = 1), a tick where the count equals the compare value (written at address 1) sets the count to zero and sets the compare flag.
- R6: A counter write (address 0) masks compare detection on the next tick: that tick sets no compare flag, does not clear the count, and advances it by one.
- R7: A counter write takes effect on the next cycle even when tick_en is high in the same cycle.
- R8: In free-running mode a tick where count equals the compare value sets the compare flag and the count keeps advancing.
- R9: A write at address 3 clears the overflow flag where data bit 0 is 1 and the compare flag where bit 1 is 1; a set on the same cycle wins over the clear.
- R10: irq_ovf is the overflow flag ANDed with enable bit 1 of address 2, irq_cmp is the compare flag ANDed with enable bit 2; ack_ovf and ack_cmp clear the matching flag unless a set happens in that cycle.
- R11: In clear-on-compare mode with compare value 0 and count 0, each tick keeps the count at 0 and sets the compare flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled timer tick; the count moves only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 count, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| ack_ovf | input | 1 | Overflow interrupt acknowledge, clears the overflow flag |
| ack_cmp | input | 1 | Compare interrupt acknowledge, clears the compare flag |
| count | output | 8 | Live count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
The assertions watch, on every cycle, that the count holds with no tick and no write, that a written value lands on the next cycle, that a tick at 0xFF always yields zero with the overflow flag set, that the overflow flag never drops without a clear source, and that a masked tick never raises the compare flag. Only the bench scenarios show the full clear-on-compare period, the set-wins-over-clear races, interrupt gating and the degenerate compare value of zero, by comparing every output against a behavioural model on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 2'd3;

  localparam int unsigned N_FLAGS = 2;
  localparam int unsigned F_OVF   = 0;
  localparam int unsigned F_CMP   = 1;

  typedef enum logic { M_FREE = 1'b0, M_CLR_ON_CMP = 1'b1 } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  ie_ovf;
    logic  ie_cmp;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              wr_count,
  output logic [W-1:0]      cmp_val,
  output ctrl_t             ctrl,
  output logic [N_FLAGS-1:0] w1c
);
  logic wr_cmp, wr_ctrl, wr_clr;

  always_comb begin
    wr_count = wr_en && (wr_addr == A_COUNT);
    wr_cmp   = wr_en && (wr_addr == A_CMP);
    wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    wr_clr   = wr_en && (wr_addr == A_CLR);
    w1c      = wr_clr ? wr_data[N_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '0;
      ctrl    <= '{mode: M_FREE, ie_ovf: 1'b0, ie_cmp: 1'b0};
    end else begin
      if (wr_cmp) cmp_val <= wr_data;
      if (wr_ctrl) begin
        ctrl.mode   <= mode_e'(wr_data[0]);
        ctrl.ie_ovf <= wr_data[1];
        ctrl.ie_cmp <= wr_data[2];
      end
    end
  end

  p_cmp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> (cmp_val == $past(wr_data)));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_count,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cmp_val,
  input  mode_e        mode,
  output logic [W-1:0] count,
  output logic         masked,
  output logic         set_ovf,
  output logic         set_cmp
);
  localparam logic [W-1:0] TOP_FREE = {W{1'b1}};

  logic         hit;
  logic         step;
  logic [W-1:0] count_nx;

  always_comb begin
    step     = tick_en && !wr_count;
    hit      = (count == cmp_val) && !masked;
    set_cmp  = step && hit;
    set_ovf  = step && (count == TOP_FREE);
    count_nx = count;
    if (wr_count)
      count_nx = wr_data;
    else if (tick_en) begin
      if ((mode == M_CLR_ON_CMP) && hit) count_nx = '0;
      else                               count_nx = count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      masked <= 1'b0;
    end else begin
      count <= count_nx;
      if (wr_count)     masked <= 1'b1;
      else if (tick_en) masked <= 1'b0;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_count) |=> $stable(count));

  p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count == $past(wr_data)));

  p_masked_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && masked) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
#(
  parameter int unsigned N = N_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              ack_ovf,
  input  logic              ack_cmp,
  output logic [W-1:0]      count,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              irq_ovf,
  output logic              irq_cmp
);
  logic               wr_count;
  logic [W-1:0]       cmp_val;
  ctrl_t              ctrl;
  logic [N_FLAGS-1:0] w1c;
  logic               masked;
  logic               set_ovf, set_cmp;
  logic [N_FLAGS-1:0] fset, fclr, flag;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_count(wr_count), .cmp_val(cmp_val),
    .ctrl(ctrl), .w1c(w1c)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_count(wr_count),
    .wr_data(wr_data), .cmp_val(cmp_val), .mode(ctrl.mode),
    .count(count), .masked(masked), .set_ovf(set_ovf), .set_cmp(set_cmp)
  );

  always_comb begin
    fset        = '0;
    fset[F_OVF] = set_ovf;
    fset[F_CMP] = set_cmp;
    fclr        = w1c;
    fclr[F_OVF] = w1c[F_OVF] | ack_ovf;
    fclr[F_CMP] = w1c[F_CMP] | ack_cmp;
  end

  tmr_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .flag(flag)
  );

  assign ovf_flag = flag[F_OVF];
  assign cmp_flag = flag[F_CMP];
  assign irq_ovf  = ovf_flag & ctrl.ie_ovf;
  assign irq_cmp  = cmp_flag & ctrl.ie_cmp;

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_count && (count == {W{1'b1}})) |=> ((count == '0) && ovf_flag));

  p_no_match_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && masked && !wr_count) |=> !$rose(cmp_flag));

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf |-> ovf_flag) and (irq_cmp |-> cmp_flag));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, wr_en = 1'b0, ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count;
  logic       ovf_flag, cmp_flag, irq_ovf, irq_cmp;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit started = 0;

  // behavioural model state
  int m_cnt = 0, m_cmp = 0;
  bit m_mode = 0, m_ieo = 0, m_iec = 0, m_blk = 0, m_ovf = 0, m_cf = 0;

  always #5 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
    .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_mode = 0; m_ieo = 0; m_iec = 0;
      m_blk = 0; m_ovf = 0; m_cf = 0;
    end else begin
      bit wc, hitv, ovs, cms;
      wc = wr_en && wr_addr == 2'd0;
      hitv = (m_cnt == m_cmp) && !m_blk;
      ovs = 0; cms = 0;
      if (wc) begin
        m_cnt = wr_data; m_blk = 1;
      end else if (tick_en) begin
        cms = hitv;
        ovs = (m_cnt == 255);
        if (m_mode && hitv) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % 256;
        m_blk = 0;
      end
      if (wr_en && wr_addr == 2'd1) m_cmp = wr_data;
      if (wr_en && wr_addr == 2'd2) begin
        m_mode = wr_data[0]; m_ieo = wr_data[1]; m_iec = wr_data[2];
      end
      if (ovs) m_ovf = 1;
      else if (ack_ovf || (wr_en && wr_addr == 2'd3 && wr_data[0])) m_ovf = 0;
      if (cms) m_cf = 1;
      else if (ack_cmp || (wr_en && wr_addr == 2'd3 && wr_data[1])) m_cf = 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      check("R2", "model count", count, m_cnt);
      check("R4", "model ovf_flag", ovf_flag, m_ovf);
      check("R8", "model cmp_flag", cmp_flag, m_cf);
      check("R10", "model irq_ovf", irq_ovf, m_ovf && m_ieo);
      check("R10", "model irq_cmp", irq_cmp, m_cf && m_iec);
    end
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // one cycle of stimulus, called at a falling edge, returns at the next one
  task automatic cyc(bit t, bit we, logic [1:0] a, logic [7:0] d, bit ao, bit ac);
    tick_en = t; wr_en = we; wr_addr = a; wr_data = d; ack_ovf = ao; ack_cmp = ac;
    @(negedge clk);
    tick_en = 0; wr_en = 0; ack_ovf = 0; ack_cmp = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 2'd0, 8'd0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    check("R1", "reset count", count, 0);
    check("R1", "reset ovf_flag", ovf_flag, 0);
    check("R1", "reset cmp_flag", cmp_flag, 0);
    check("R1", "reset irqs", {irq_ovf, irq_cmp}, 0);

    // cmp is 0 after reset: move it away first
    cyc(0, 1, 2'd1, 8'd200, 0, 0);
    ticks(5);
    check("R2", "count after 5 ticks", count, 5);
    repeat (3) cyc(0, 0, 2'd0, 8'd0, 0, 0);
    check("R2", "count held without ticks", count, 5);

    // write with tick in same cycle
    cyc(1, 1, 2'd0, 8'hFD, 0, 0);
    check("R7", "write beats tick", count, 8'hFD);
    ticks(2);
    check("R3", "count at top", count, 8'hFF);
    check("R3", "ovf before wrap", ovf_flag, 0);
    ticks(1);
    check("R3", "count wrapped", count, 0);
    check("R3", "ovf set on wrap", ovf_flag, 1);
    ticks(4);
    check("R4", "ovf sticky", ovf_flag, 1);
    cyc(0, 1, 2'd2, 8'b010, 0, 0);
    check("R10", "irq_ovf enabled", irq_ovf, 1);
    cyc(0, 0, 2'd0, 8'd0, 1, 0);
    check("R10", "ack clears ovf", ovf_flag, 0);
    check("R10", "irq_ovf dropped", irq_ovf, 0);

    // set wins over write-one-to-clear
    cyc(0, 1, 2'd0, 8'hFF, 0, 0);
    tick_en = 1; wr_en = 1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    tick_en = 0; wr_en = 0;
    check("R9", "set beats clear", ovf_flag, 1);
    cyc(0, 1, 2'd3, 8'h01, 0, 0);
    check("R9", "w1c clears ovf", ovf_flag, 0);

    // free-running compare
    cyc(0, 1, 2'd1, 8'd3, 0, 0);
    cyc(0, 1, 2'd0, 8'd0, 0, 0);
    ticks(3);
    check("R8", "no flag before match", cmp_flag, 0);
    ticks(1);
    check("R8", "flag on match", cmp_flag, 1);
    check("R8", "count continues", count, 4);
    cyc(0, 1, 2'd3, 8'h02, 0, 0);
    check("R9", "w1c clears cmp", cmp_flag, 0);

    // clear-on-compare period
    cyc(0, 1, 2'd2, 8'b101, 0, 0);
    cyc(0, 1, 2'd0, 8'd0, 0, 0);
    ticks(3);
    check("R5", "count reaches top", count, 3);
    ticks(1);
    check("R5", "count cleared", count, 0);
    check("R5", "cmp flag set", cmp_flag, 1);
    check("R10", "irq_cmp enabled", irq_cmp, 1);
    cyc(0, 0, 2'd0, 8'd0, 0, 1);
    check("R10", "ack clears cmp", cmp_flag, 0);

    // masked match after write
    cyc(0, 1, 2'd0, 8'd3, 0, 0);
    ticks(1);
    check("R6", "masked: count advanced", count, 4);
    check("R6", "masked: no flag", cmp_flag, 0);

    // compare value zero
    cyc(0, 1, 2'd1, 8'd0, 0, 0);
    cyc(0, 1, 2'd0, 8'hFF, 0, 0);
    ticks(1);
    check("R11", "wrap into zero", count, 0);
    ticks(3);
    check("R11", "count stays zero", count, 0);
    check("R11", "cmp flag on zero", cmp_flag, 1);
    tick_en = 1; wr_en = 1; wr_addr = 2'd3; wr_data = 8'h02;
    @(negedge clk);
    tick_en = 0; wr_en = 0;
    check("R11", "flag re-set each tick", cmp_flag, 1);
    check("R11", "still zero", count, 0);

    ticks(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule